// File: doc/BRIEF.md
# Crosspoint Chain Programming Master

This block sits on the host side of a board that carries one or more analog crosspoint switch devices. The devices are controlled over a slow serial link made of a clock, an active-low select, a data line, a mode line and a commit strobe. The block accepts one request per transfer. A request is either a complete routing table for every device in a daisy chain, or a single addressed update that changes one output of one device. The block turns the request into a correctly ordered bit stream on the serial pins.

The block keeps to the link's timing discipline. Select falls a programmable number of system clocks before the first serial clock rise. Select only moves while the serial clock is low. Data changes only as the serial clock rises, so it is stable across every falling edge, where the device samples it. After the last bit, select is raised and one more rising serial clock edge is produced. Only after that is the configuration committed. In the four-wire variant, commit is a separate pulse of programmable width that is issued once the whole chain has been loaded, so every device switches at the same moment. In the three-wire variant, select and commit share one line, and raising it ends the transfer and commits at once.

The serial half period, the select lead time, the commit pulse width, the chain length and the wiring variant are compile-time parameters: `HALF_CLKS`, `LEAD_CLKS`, `COMMIT_CLKS`, `NDEV` and `THREE_WIRE`.

Top module: `xbp_chain_master`

## Requirements
- R1: A request (`req_valid` high) is accepted only while `busy` is low. `busy` is high from the next cycle until the transfer and commit finish. A request presented while `busy` is high is ignored: it changes neither the stream nor the number of `done` pulses.
- R2: `done` is a single-cycle pulse in the first cycle in which `busy` is low again. Each accepted request gives exactly one pulse.
- R3: `ser_sel_n` changes only when `ser_clk` is low both before and after the change.
- R4: `ser_sel_n` is low for at least `LEAD_CLKS` system clocks before the first rising edge of `ser_clk` in a transfer.
- R5: `ser_data` changes only while `ser_clk` is low, or together with its rise. Every data bit is presented with `ser_clk` high for exactly `HALF_CLKS` system clocks before the falling edge that samples it.
- R6: With `req_single`=0, `ser_mode` is 0 and 40·NDEV bits are sent. The slice of device NDEV-1 (the farthest) goes first and device 0 goes last. Within the slice of device d, bit k of `route_table[40d+39:40d]` is sent k-th, with k=0 first. Output o of a device occupies slice bits 5o..5o+4. Bits 5o..5o+3 hold its input index, LSB first, and bit 5o+4 is 1 to disable that output.
- R7: With `req_single`=1, `ser_mode` is 1 and 8 bits are sent in this order: `upd_out[0..2]`, then `upd_in[0..3]`, then `upd_off` (1 = output disabled).
- R8: After the last data bit, `ser_sel_n` rises while `ser_clk` is low. `ser_clk` then makes at least one rising edge before the commit (four-wire) or before `done` (three-wire).
- R9: In the four-wire variant, `ser_commit` is never high while `ser_sel_n` is low. Each transfer produces exactly one commit pulse, `COMMIT_CLKS` cycles wide.
- R10: In the three-wire variant, `ser_commit` is the select line itself, idle high. There is no separate pulse, and `done` arrives `COMMIT_CLKS` cycles earlier than in the four-wire variant for the same request.
- R11: `ser_mode` holds its value while `ser_sel_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_single | input | 1 | 1 = addressed single update, 0 = full chain table |
| route_table | input | 40·NDEV | Routing table, 40 bits per device (layout in R6) |
| upd_out | input | 3 | Output index for an addressed update |
| upd_in | input | 4 | Input index for an addressed update |
| upd_off | input | 1 | 1 = disable the addressed output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_sel_n | output | 1 | Active-low device select |
| ser_data | output | 1 | Serial data |
| ser_mode | output | 1 | Frame format: 1 addressed, 0 full |
| ser_commit | output | 1 | Commit strobe (the select line in the three-wire variant) |

## Verification
The assertions assume that `req_valid` is never raised during the two cycles in which the internal reset is still being released. They also assume that the parameters give each timed phase at least one cycle. The bench waits several cycles after reset before issuing a request, and it holds the request fields only for the accept cycle. Some requests are made while the block is busy, and those carry deliberately different fields, so that any leak into the stream would be visible. The sweep covers every output, input and disable combination of the addressed update. It also applies full tables whose two device slices differ, so that a reversed device order shows up.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  localparam int unsigned OUTS_PER_DEV = 8;
  localparam int unsigned IN_IDX_W     = 4;
  localparam int unsigned OUT_IDX_W    = 3;
  localparam int unsigned SLOT_W       = IN_IDX_W + 1;
  localparam int unsigned DEV_FRAME_W  = OUTS_PER_DEV * SLOT_W;
  localparam int unsigned UPD_W        = OUT_IDX_W + IN_IDX_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_RELEASE,
    ST_TAIL_HI,
    ST_TAIL_LO,
    ST_COMMIT
  } seq_state_e;
endpackage

// File: rtl/xbp_frame_pack.sv
module xbp_frame_pack
  import xbp_pkg::*;
#(
  parameter int unsigned NDEV = 2
) (
  input  logic [NDEV*DEV_FRAME_W-1:0] table_i,
  output logic [NDEV*DEV_FRAME_W-1:0] stream_o
);
  // Stream slot 0 (shifted first) carries the farthest device.
  for (genvar d = 0; d < NDEV; d++) begin : g_slot
    assign stream_o[d*DEV_FRAME_W +: DEV_FRAME_W] =
      table_i[(NDEV-1-d)*DEV_FRAME_W +: DEV_FRAME_W];
  end
endmodule

// File: rtl/xbp_shifter.sv
module xbp_shifter #(
  parameter int unsigned W     = 80,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     load_vec,
  input  logic [CNT_W-1:0] load_len,
  input  logic             shift,
  output logic             bit_o,
  output logic             last_o
);
  logic [W-1:0]     sreg_q, sreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (load) begin
      sreg_d = load_vec;
      cnt_d  = load_len;
    end else if (shift) begin
      sreg_d = {1'b0, sreg_q[W-1:1]};
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
    end
  end

  assign bit_o  = sreg_q[0];
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/xbp_timer.sv
module xbp_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xbp_chain_master.sv
module xbp_chain_master
  import xbp_pkg::*;
#(
  parameter int unsigned NDEV        = 2,
  parameter int unsigned HALF_CLKS   = 2,
  parameter int unsigned LEAD_CLKS   = 3,
  parameter int unsigned COMMIT_CLKS = 2,
  parameter bit          THREE_WIRE  = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_single,
  input  logic [NDEV*DEV_FRAME_W-1:0] route_table,
  input  logic [OUT_IDX_W-1:0]        upd_out,
  input  logic [IN_IDX_W-1:0]         upd_in,
  input  logic                        upd_off,
  output logic                        busy,
  output logic                        done,
  output logic                        ser_clk,
  output logic                        ser_sel_n,
  output logic                        ser_data,
  output logic                        ser_mode,
  output logic                        ser_commit
);
  localparam int unsigned FRAME_W = NDEV * DEV_FRAME_W;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);
  localparam int unsigned T_A     = (HALF_CLKS > LEAD_CLKS) ? HALF_CLKS : LEAD_CLKS;
  localparam int unsigned T_MAX   = (T_A > COMMIT_CLKS) ? T_A : COMMIT_CLKS;
  localparam int unsigned TMR_W   = $clog2(T_MAX + 1);
  localparam logic [TMR_W-1:0] HALF_LD   = TMR_W'(HALF_CLKS - 1);
  localparam logic [TMR_W-1:0] LEAD_LD   = TMR_W'(LEAD_CLKS - 1);
  localparam logic [TMR_W-1:0] COMMIT_LD = TMR_W'(COMMIT_CLKS - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  seq_state_e         state_q, state_d;
  logic               mode_q, mode_d;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic               sh_load, sh_shift, sh_bit, sh_last;
  logic [FRAME_W-1:0] packed_tbl, load_vec;
  logic [LEN_W-1:0]   load_len;
  logic               sclk_q, sclk_d, sel_n_q, sel_n_d, done_q, done_d;

  xbp_frame_pack #(.NDEV(NDEV)) pack_i (
    .table_i (route_table),
    .stream_o(packed_tbl)
  );

  assign load_vec = req_single ? FRAME_W'({upd_off, upd_in, upd_out}) : packed_tbl;
  assign load_len = req_single ? LEN_W'(UPD_W) : LEN_W'(FRAME_W);

  xbp_shifter #(.W(FRAME_W), .CNT_W(LEN_W)) shift_i (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load    (sh_load),
    .load_vec(load_vec),
    .load_len(load_len),
    .shift   (sh_shift),
    .bit_o   (sh_bit),
    .last_o  (sh_last)
  );

  xbp_timer #(.W(TMR_W)) timer_i (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero_o  (tmr_zero)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        sh_load  = 1'b1;
        mode_d   = req_single;
        state_d  = ST_LEAD;
        tmr_load = 1'b1;
        tmr_val  = LEAD_LD;
      end
      ST_LEAD: if (tmr_zero) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
      end
      ST_HIGH: if (tmr_zero) begin
        state_d  = ST_LOW;
        tmr_load = 1'b1;
      end
      ST_LOW: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          state_d = ST_RELEASE;
        end else begin
          sh_shift = 1'b1;
          state_d  = ST_HIGH;
        end
      end
      ST_RELEASE: if (tmr_zero) begin
        state_d  = ST_TAIL_HI;
        tmr_load = 1'b1;
      end
      ST_TAIL_HI: if (tmr_zero) begin
        state_d  = ST_TAIL_LO;
        tmr_load = 1'b1;
      end
      ST_TAIL_LO: if (tmr_zero) begin
        if (THREE_WIRE) begin
          state_d = ST_IDLE;
        end else begin
          state_d  = ST_COMMIT;
          tmr_load = 1'b1;
          tmr_val  = COMMIT_LD;
        end
      end
      ST_COMMIT: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // serial pins are registered, decoded from the next state
  assign sclk_d  = (state_d == ST_HIGH) || (state_d == ST_TAIL_HI);
  assign sel_n_d = !((state_d == ST_LEAD) || (state_d == ST_HIGH) || (state_d == ST_LOW));
  assign done_d  = (state_q != ST_IDLE) && (state_d == ST_IDLE);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      sclk_q  <= 1'b0;
      sel_n_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      sclk_q  <= sclk_d;
      sel_n_q <= sel_n_d;
      done_q  <= done_d;
    end
  end

  if (THREE_WIRE) begin : g_shared_line
    assign ser_commit = sel_n_q;
  end else begin : g_own_strobe
    logic commit_q, commit_d;
    assign commit_d = (state_d == ST_COMMIT);
    always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) commit_q <= 1'b0;
      else             commit_q <= commit_d;
    end
    assign ser_commit = commit_q;
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ser_clk   = sclk_q;
  assign ser_sel_n = sel_n_q;
  assign ser_data  = sh_bit;
  assign ser_mode  = mode_q;
endmodule

// File: rtl/xbp_chain_master_chk.sv
module xbp_chain_master_chk #(
  parameter int unsigned LEAD_CLKS  = 3,
  parameter bit          THREE_WIRE = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_sel_n,
  input logic ser_data,
  input logic ser_mode,
  input logic ser_commit
);
  localparam int unsigned LW = $clog2(LEAD_CLKS + 2);

  logic          clk_q, rise_seen_q, tail_seen_q;
  logic [LW-1:0] lead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q       <= 1'b0;
      rise_seen_q <= 1'b0;
      tail_seen_q <= 1'b0;
      lead_q      <= '0;
    end else begin
      clk_q <= ser_clk;
      if (ser_sel_n) begin
        rise_seen_q <= 1'b0;
        lead_q      <= '0;
        tail_seen_q <= tail_seen_q || (ser_clk && !clk_q);
      end else begin
        tail_seen_q <= 1'b0;
        if (ser_clk && !clk_q) rise_seen_q <= 1'b1;
        if (!rise_seen_q && !ser_clk && lead_q < LW'(LEAD_CLKS)) lead_q <= lead_q + 1'b1;
      end
    end
  end

  assert_sel_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_n != $past(ser_sel_n)) |-> (!ser_clk && !$past(ser_clk)));

  assert_lead_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel_n && ser_clk && !clk_q && !rise_seen_q) |-> (lead_q >= LW'(LEAD_CLKS)));

  assert_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ser_clk) |-> $stable(ser_data));

  assert_tail_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((THREE_WIRE == 1'b0) && $rose(ser_commit)) |-> tail_seen_q);

  assert_commit_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((THREE_WIRE == 1'b0) && ser_commit) |-> ser_sel_n);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel_n && !$past(ser_sel_n)) |-> $stable(ser_mode));
endmodule

bind xbp_chain_master xbp_chain_master_chk #(
  .LEAD_CLKS (LEAD_CLKS),
  .THREE_WIRE(THREE_WIRE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .ser_clk   (ser_clk),
  .ser_sel_n (ser_sel_n),
  .ser_data  (ser_data),
  .ser_mode  (ser_mode),
  .ser_commit(ser_commit)
);

// File: tb/xbp_chain_master_tb_top.sv
module xbp_bus_mon #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic sclk,
  input logic sel_n,
  input logic sdata,
  input logic mode,
  input logic commit
);
  logic [255:0] cap  = '0;
  logic [255:0] capm = '0;
  int capn = 0, setup = 0, low_clks = 0, sel_bad = 0, data_bad = 0, hi_bad = 0;
  int hi_run = 0, trail = 0, trail_at_commit = 0, commit_rises = 0, commit_w = 0;
  int commit_bad = 0, mode_chg = 0;
  bit rose_seen = 0;
  logic p_clk = 0, p_sel = 1, p_data = 0, p_commit = 0, p_mode = 0;

  always @(negedge clk) begin
    if (p_sel && !sel_n) begin
      capn = 0; setup = 0; low_clks = 0; sel_bad = 0; data_bad = 0; hi_bad = 0;
      hi_run = 0; trail = 0; trail_at_commit = 0; commit_rises = 0; commit_w = 0;
      commit_bad = 0; mode_chg = 0; rose_seen = 0;
    end
    if ((sel_n != p_sel) && (sclk || p_clk)) sel_bad++;
    if (!sel_n && sclk && !p_clk && !rose_seen) begin
      rose_seen = 1;
      setup = low_clks;
    end
    if (!sel_n && !rose_seen) low_clks++;
    if (p_clk && (sdata != p_data)) data_bad++;
    if (sclk) hi_run++;
    if (p_clk && !sclk) begin
      if (!sel_n) begin
        if (hi_run != HALF) hi_bad++;
        if (capn < 256) begin
          cap[capn]  = sdata;
          capm[capn] = mode;
        end
        capn++;
      end
      hi_run = 0;
    end
    if (sel_n && sclk && !p_clk) trail++;
    if (commit && !p_commit) begin
      commit_rises++;
      trail_at_commit = trail;
    end
    if (commit) commit_w++;
    if (commit && !sel_n) commit_bad++;
    if (!sel_n && !p_sel && (mode != p_mode)) mode_chg++;
    p_clk = sclk; p_sel = sel_n; p_data = sdata; p_commit = commit; p_mode = mode;
  end
endmodule

module xbp_chain_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV       = 2;
  localparam int HALF       = 2;
  localparam int LEAD       = 3;
  localparam int COMMIT     = 2;
  localparam int FRAME_W    = NDEV * 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic               req_valid = 1'b0, req_single = 1'b0, upd_off = 1'b0;
  logic [FRAME_W-1:0] route_table = '0;
  logic [2:0]         upd_out = '0;
  logic [3:0]         upd_in = '0;

  logic busy4, done4, sclk4, sel4, data4, mode4, com4;
  logic busy3, done3, sclk3, sel3, data3, mode3, com3;

  xbp_chain_master #(.NDEV(NDEV), .HALF_CLKS(HALF), .LEAD_CLKS(LEAD),
                     .COMMIT_CLKS(COMMIT), .THREE_WIRE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
    .route_table(route_table), .upd_out(upd_out), .upd_in(upd_in), .upd_off(upd_off),
    .busy(busy4), .done(done4), .ser_clk(sclk4), .ser_sel_n(sel4), .ser_data(data4),
    .ser_mode(mode4), .ser_commit(com4));

  xbp_chain_master #(.NDEV(NDEV), .HALF_CLKS(HALF), .LEAD_CLKS(LEAD),
                     .COMMIT_CLKS(COMMIT), .THREE_WIRE(1'b1)) dut_tw_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
    .route_table(route_table), .upd_out(upd_out), .upd_in(upd_in), .upd_off(upd_off),
    .busy(busy3), .done(done3), .ser_clk(sclk3), .ser_sel_n(sel3), .ser_data(data3),
    .ser_mode(mode3), .ser_commit(com3));

  xbp_bus_mon #(.HALF(HALF)) mon4_i (.clk(clk), .sclk(sclk4), .sel_n(sel4),
    .sdata(data4), .mode(mode4), .commit(com4));
  xbp_bus_mon #(.HALF(HALF)) mon3_i (.clk(clk), .sclk(sclk3), .sel_n(sel3),
    .sdata(data3), .mode(mode3), .commit(com3));

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic bit exp_bit(input bit single, input logic [FRAME_W-1:0] tbl,
                                 input logic [2:0] o, input logic [3:0] i,
                                 input bit off, input int p);
    if (single) begin
      if (p < 3) return o[p];
      if (p < 7) return i[p-3];
      return off;
    end
    return tbl[(NDEV - 1 - p/40)*40 + (p % 40)];
  endfunction

  task automatic chk_stream(input string who, input bit single, input logic [FRAME_W-1:0] tbl,
                            input logic [2:0] o, input logic [3:0] i, input bit off,
                            input int capn, input logic [255:0] cap, input logic [255:0] capm,
                            input int setup, input int sel_bad, input int data_bad,
                            input int hi_bad, input int mode_chg);
    int len = single ? 8 : FRAME_W;
    int miss = 0;
    int mmiss = 0;
    string ftag = single ? "R7" : "R6";
    for (int p = 0; p < len; p++) begin
      if (cap[p] != exp_bit(single, tbl, o, i, off, p)) miss++;
      if (capm[p] != single) mmiss++;
    end
    chk(capn == len, {ftag, " bit count ", who}, capn, len);
    chk(miss == 0, {ftag, " bit values ", who}, miss, 0);
    chk(mmiss == 0, {"R11 mode level ", who}, mmiss, 0);
    chk(mode_chg == 0, {"R11 mode hold ", who}, mode_chg, 0);
    chk(setup >= LEAD, {"R4 select lead ", who}, setup, LEAD);
    chk(sel_bad == 0, {"R3 select with clock high ", who}, sel_bad, 0);
    chk(data_bad == 0, {"R5 data moved while clock high ", who}, data_bad, 0);
    chk(hi_bad == 0, {"R5 high phase length ", who}, hi_bad, 0);
  endtask

  task automatic run_one(input bit single, input logic [FRAME_W-1:0] tbl,
                         input logic [2:0] o, input logic [3:0] i, input bit off,
                         input bit poke);
    int d4 = 0, d3 = 0, t4 = -1, t3 = -1, b4 = 0, b3 = 0, t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_single = single; route_table = tbl;
    upd_out = o; upd_in = i; upd_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy4 && busy3, "R1 busy after accept", {busy4, busy3}, 3);
    if (poke) begin
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_single = !single; route_table = ~tbl;
      upd_out = ~o; upd_in = ~i; upd_off = !off;
      @(negedge clk);
      req_valid = 1'b0;
    end
    for (t = 0; t < 3000; t++) begin
      if (done4) begin d4++; t4 = t; b4 = busy4; end
      if (done3) begin d3++; t3 = t; b3 = busy3; end
      if (d4 != 0 && d3 != 0) break;
      @(negedge clk);
    end
    chk(t < 3000, "R2 completion timeout", t, 3000);
    repeat (4) begin
      @(negedge clk);
      if (done4) d4++;
      if (done3) d3++;
    end
    chk(d4 == 1, "R2 R1 done count four-wire", d4, 1);
    chk(d3 == 1, "R2 R1 done count three-wire", d3, 1);
    chk(b4 == 0 && b3 == 0, "R2 busy low at done", {b4[0], b3[0]}, 0);
    chk(t4 - t3 == COMMIT, "R10 three-wire finishes earlier", t4 - t3, COMMIT);
    chk_stream("4w", single, tbl, o, i, off, mon4_i.capn, mon4_i.cap, mon4_i.capm,
               mon4_i.setup, mon4_i.sel_bad, mon4_i.data_bad, mon4_i.hi_bad, mon4_i.mode_chg);
    chk_stream("3w", single, tbl, o, i, off, mon3_i.capn, mon3_i.cap, mon3_i.capm,
               mon3_i.setup, mon3_i.sel_bad, mon3_i.data_bad, mon3_i.hi_bad, mon3_i.mode_chg);
    chk(mon4_i.trail_at_commit >= 1, "R8 trailing edge before commit", mon4_i.trail_at_commit, 1);
    chk(mon3_i.trail >= 1, "R8 R10 trailing edge three-wire", mon3_i.trail, 1);
    chk(mon4_i.commit_rises == 1, "R9 one commit pulse", mon4_i.commit_rises, 1);
    chk(mon4_i.commit_w == COMMIT, "R9 commit width", mon4_i.commit_w, COMMIT);
    chk(mon4_i.commit_bad == 0, "R9 commit while selected", mon4_i.commit_bad, 0);
    chk(mon3_i.commit_rises == 1, "R10 shared line rises once", mon3_i.commit_rises, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: got %0d expected %0d", 190000, 0);
    summary();
  end

  initial begin
    logic [FRAME_W-1:0] tbl;
    repeat (3) @(negedge clk);
    chk(!busy4 && !busy3, "R1 reset busy", {busy4, busy3}, 0);
    chk(!done4 && !done3, "R2 reset done", {done4, done3}, 0);
    chk(sel4 && sel3 && !sclk4 && !sclk3, "R3 reset pins", {sel4, sel3, sclk4, sclk3}, 12);
    chk(!com4, "R9 reset commit low", com4, 0);
    chk(com3, "R10 reset shared line high", com3, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 16; i++)
        for (int f = 0; f < 2; f++)
          run_one(1'b1, '0, 3'(o), 4'(i), f[0], (i == 5));

    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < FRAME_W; k++) begin
        case (n)
          0:       tbl[k] = 1'b0;
          1:       tbl[k] = 1'b1;
          2:       tbl[k] = k[0];
          3:       tbl[k] = (k >= 40);
          4:       tbl[k] = (k < 40);
          5:       tbl[k] = ((k % 40) < 5);
          default: tbl[k] = 1'($urandom);
        endcase
      end
      run_one(1'b0, tbl, 3'(n), 4'(n), n[0], (n % 3 == 0));
    end
    summary();
  end
endmodule